// File: doc/BRIEF.md
# Floating-Compare and Register-Sign Branch Resolver

This block settles the direction and the next fetch address of a conditional branch once its operand is known. It covers two families of branch. The first tests a two-bit floating-point compare outcome against a four-bit condition. The second tests the sign and zero status of a signed register value against a three-bit condition. The caller presents one branch per cycle with `in_valid`. The block returns the resolved direction, the next program counter, a mispredict flag and a strobe for updating the direction predictor, all registered, one cycle later with `res_valid`.

The floating condition is a one-hot-per-outcome mask. Bit k of `in_fcond` allows the branch to be taken when the compare outcome equals k. With four outcomes, the sixteen mask values cover every combination of outcomes, including always and never. The register condition keeps fixed code points, and two of them are reserved and never taken.

A two-state controller sequences the output. `ST_IDLE` holds while no branch is pending. The transition `GO_RESULT` (in_valid high) enters `ST_RESULT`, where the captured result is presented. `ST_RESULT` stays put on another `in_valid` (transition `STAY_RESULT`, back-to-back branches) and returns to `ST_IDLE` through `GO_IDLE` when `in_valid` is low.

Top module: `branch_resolver`

## Requirements
- R1: Compare outcomes are encoded equal=0, less=1, greater=2, unordered=3. In float mode (`in_mode`=0) the branch is taken exactly when bit `in_fcc` of `in_fcond` is 1. A single-bit mask selects one outcome: 0001 equal, 0010 less, 0100 greater, 1000 unordered.
- R2: Multi-bit masks are unions of outcomes. 1111 is always taken and 0000 is never taken. Not-equal (1110) is taken for less, greater or unordered. Ordered (0111) is taken for equal, less or greater.
- R3: In register mode (`in_mode`=1) the value is compared as signed. The codes are: 1 taken if zero, 2 taken if ≤ 0, 3 taken if negative, 5 taken if nonzero, 6 taken if > 0, 7 taken if ≥ 0.
- R4: Register condition codes 0 and 4 are reserved and are never taken, whatever the value.
- R5: A taken branch sets `res_next_pc` to `in_pc` plus the sign-extended `in_disp` times 4, modulo 2^PC_W.
- R6: A not-taken branch sets `res_next_pc` to `in_pc` + 8, modulo 2^PC_W.
- R7: `res_bp_update` is raised with every register-mode result. It is raised with every float-mode result except for mask 0000, where it stays low.
- R8: `res_mispredict` is 1 exactly when `res_taken` differs from the `in_pred_taken` captured with the branch.
- R9: A result appears with `res_valid` on the cycle after `in_valid` was sampled high, and one result appears for each cycle of `in_valid`. While `res_valid` is low, `res_taken`, `res_mispredict` and `res_bp_update` are 0.
- R10: While `rst_n` is low, and afterwards until the first branch is accepted, `res_valid` is 0. Asserting reset discards a pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Branch presented this cycle |
| in_mode | input | 1 | 0 float compare, 1 register sign |
| in_fcc | input | 2 | Compare outcome |
| in_fcond | input | 4 | Float outcome mask |
| in_rval | input | REG_W | Register value (signed) |
| in_rcond | input | 3 | Register condition code |
| in_pc | input | PC_W | Branch address |
| in_disp | input | DISP_W | Signed word displacement |
| in_pred_taken | input | 1 | Predicted direction |
| res_valid | output | 1 | Result valid |
| res_taken | output | 1 | Resolved direction |
| res_next_pc | output | PC_W | Next fetch address |
| res_mispredict | output | 1 | Prediction was wrong |
| res_bp_update | output | 1 | Predictor update strobe |

## Verification
The case hardest to reach from the ports is the unordered outcome combined with a union mask. It takes a compare outcome that ordinary float values rarely produce, paired with the not-equal and ordered masks, where the unordered case flips the result. The stimulus table pairs outcome 3 with every mask that contains or excludes it. The table also places reserved register codes next to values that would satisfy their neighbouring codes. Directed tests drive back-to-back valids, which keep the controller in `ST_RESULT`. Further directed tests cover a not-taken branch whose PC+8 wraps past zero, a negative displacement, and a reset that discards a pending result.

// File: rtl/brr_pkg.sv
package brr_pkg;
    typedef enum logic {
        MODE_FCC = 1'b0,
        MODE_REG = 1'b1
    } mode_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } state_e;

    // compare outcome code points; the float mask is indexed by them
    localparam logic [1:0] FCC_EQ = 2'd0;
    localparam logic [1:0] FCC_LT = 2'd1;
    localparam logic [1:0] FCC_GT = 2'd2;
    localparam logic [1:0] FCC_UO = 2'd3;

    localparam logic [3:0] FMASK_NEVER  = 4'b0000;
    localparam logic [3:0] FMASK_ALWAYS = 4'b1111;
endpackage

// File: rtl/brr_fcc_eval.sv
module brr_fcc_eval
    import brr_pkg::*;
(
    input  logic [1:0] fcc,
    input  logic [3:0] fmask,
    output logic       taken,
    output logic       strobe
);
    always_comb begin
        unique case (fcc)
            FCC_EQ:  taken = fmask[0];
            FCC_LT:  taken = fmask[1];
            FCC_GT:  taken = fmask[2];
            default: taken = fmask[3];
        endcase
        strobe = (fmask != FMASK_NEVER);
    end
endmodule

// File: rtl/brr_reg_eval.sv
module brr_reg_eval #(
    parameter int REG_W = 32
) (
    input  logic [REG_W-1:0] rval,
    input  logic [2:0]       rcond,
    output logic             taken
);
    logic is_zero;
    logic is_neg;

    assign is_zero = (rval == '0);
    assign is_neg  = rval[REG_W-1];

    always_comb begin
        unique case (rcond)
            3'd1:    taken = is_zero;
            3'd2:    taken = is_zero | is_neg;
            3'd3:    taken = is_neg;
            3'd5:    taken = !is_zero;
            3'd6:    taken = !is_zero && !is_neg;
            3'd7:    taken = !is_neg;
            default: taken = 1'b0;  // codes 0 and 4 reserved
        endcase
    end
endmodule

// File: rtl/brr_target.sv
module brr_target #(
    parameter int PC_W   = 32,
    parameter int DISP_W = 22
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [DISP_W-1:0] disp,
    input  logic              taken,
    output logic [PC_W-1:0]   next_pc
);
    localparam int WORD_SHIFT = 2;
    localparam logic [PC_W-1:0] SEQ_STEP = PC_W'(8);

    logic [PC_W-1:0] offset;

    generate
        if (DISP_W >= PC_W) begin : g_trunc
            assign offset = disp[PC_W-1:0] << WORD_SHIFT;
        end else begin : g_sext
            assign offset = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp} << WORD_SHIFT;
        end
    endgenerate

    assign next_pc = taken ? (pc + offset) : (pc + SEQ_STEP);
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
    import brr_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int REG_W  = 32,
    parameter int DISP_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_mode,
    input  logic [1:0]        in_fcc,
    input  logic [3:0]        in_fcond,
    input  logic [REG_W-1:0]  in_rval,
    input  logic [2:0]        in_rcond,
    input  logic [PC_W-1:0]   in_pc,
    input  logic [DISP_W-1:0] in_disp,
    input  logic              in_pred_taken,
    output logic              res_valid,
    output logic              res_taken,
    output logic [PC_W-1:0]   res_next_pc,
    output logic              res_mispredict,
    output logic              res_bp_update
);
    state_e          state_q, state_d;
    logic            f_taken, f_strobe, r_taken;
    logic            taken_now, strobe_now;
    logic [PC_W-1:0] npc_now;
    logic            taken_q, mis_q, upd_q;
    logic [PC_W-1:0] npc_q;

    brr_fcc_eval u_fcc (
        .fcc    (in_fcc),
        .fmask  (in_fcond),
        .taken  (f_taken),
        .strobe (f_strobe)
    );

    brr_reg_eval #(.REG_W(REG_W)) u_reg (
        .rval  (in_rval),
        .rcond (in_rcond),
        .taken (r_taken)
    );

    assign taken_now  = (in_mode == MODE_REG) ? r_taken : f_taken;
    assign strobe_now = (in_mode == MODE_REG) ? 1'b1    : f_strobe;

    brr_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_tgt (
        .pc      (in_pc),
        .disp    (in_disp),
        .taken   (taken_now),
        .next_pc (npc_now)
    );

    // transitions: GO_RESULT, STAY_RESULT, GO_IDLE
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q <= 1'b0;
            mis_q   <= 1'b0;
            upd_q   <= 1'b0;
            npc_q   <= '0;
        end else if (in_valid) begin
            taken_q <= taken_now;
            mis_q   <= taken_now ^ in_pred_taken;
            upd_q   <= strobe_now;
            npc_q   <= npc_now;
        end
    end

    always_comb begin
        res_valid      = (state_q == ST_RESULT);
        res_taken      = res_valid & taken_q;
        res_mispredict = res_valid & mis_q;
        res_bp_update  = res_valid & upd_q;
        res_next_pc    = npc_q;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_taken && !res_mispredict && !res_bp_update)); // R9
    AST_NEVER_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == MODE_FCC && in_fcond == FMASK_NEVER) |=> (!res_bp_update && !res_taken)); // R7
    AST_REG_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == MODE_REG) |=> res_bp_update); // R7
    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == MODE_FCC && in_fcond == FMASK_ALWAYS) |=> res_taken); // R2
    AST_RSVD_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == MODE_REG && (in_rcond == 3'd0 || in_rcond == 3'd4)) |=> !res_taken); // R4
    AST_FALLTHRU_PC: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (res_taken || res_next_pc == $past(in_pc) + PC_W'(8))); // R6
    AST_MISPREDICT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (res_mispredict == (res_taken != $past(in_pred_taken)))); // R8
endmodule

// File: tb/test_branch_resolver.sv
module test_branch_resolver;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        mode;
        logic [1:0]  fcc;
        logic [3:0]  fcond;
        logic [31:0] rval;
        logic [2:0]  rcond;
        logic [31:0] pc;
        logic [21:0] disp;
        logic        pred;
        logic        exp_taken;
    } vec_t;

    localparam int NV = 26;
    // mode 0: taken iff fcond[fcc]; mode 1: signed register codes (R1..R4)
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 4'b0001, 32'hDEAD_BEEF, 3'd3, 32'h0000_1000, 22'd16, 1'b1, 1'b1},   // R1 eq
        '{1'b0, 2'd1, 4'b0001, 32'h0,        3'd0, 32'h0000_1000, 22'd16, 1'b1, 1'b0},   // R1
        '{1'b0, 2'd1, 4'b0010, 32'h0,        3'd0, 32'h0000_2000, 22'd5,  1'b0, 1'b1},   // R1 lt
        '{1'b0, 2'd2, 4'b0100, 32'h0,        3'd0, 32'h0000_2000, 22'h3FFFFC, 1'b0, 1'b1}, // R1 gt, neg disp
        '{1'b0, 2'd3, 4'b1000, 32'h0,        3'd0, 32'h0000_3000, 22'd1,  1'b1, 1'b1},   // R1 uo
        '{1'b0, 2'd2, 4'b1000, 32'h0,        3'd0, 32'h0000_3000, 22'd1,  1'b1, 1'b0},   // R1
        '{1'b0, 2'd3, 4'b1110, 32'h0,        3'd0, 32'h0000_4000, 22'd8,  1'b0, 1'b1},   // R2 ne uo
        '{1'b0, 2'd0, 4'b1110, 32'h0,        3'd0, 32'h0000_4000, 22'd8,  1'b1, 1'b0},   // R2 ne eq
        '{1'b0, 2'd3, 4'b0111, 32'h0,        3'd0, 32'h0000_4000, 22'd8,  1'b1, 1'b0},   // R2 ord uo
        '{1'b0, 2'd1, 4'b0111, 32'h0,        3'd0, 32'h0000_4000, 22'd8,  1'b0, 1'b1},   // R2 ord lt
        '{1'b0, 2'd2, 4'b1111, 32'h0,        3'd0, 32'h0000_5000, 22'd2,  1'b0, 1'b1},   // R2 always
        '{1'b0, 2'd1, 4'b0000, 32'h0,        3'd0, 32'h0000_5000, 22'd2,  1'b1, 1'b0},   // R2 never
        '{1'b0, 2'd2, 4'b1100, 32'h0,        3'd0, 32'h0000_5000, 22'd2,  1'b0, 1'b1},   // R2 ug
        '{1'b0, 2'd0, 4'b1011, 32'h0,        3'd0, 32'h0000_6000, 22'd3,  1'b0, 1'b1},   // R2 ule
        '{1'b0, 2'd2, 4'b1011, 32'h0,        3'd0, 32'h0000_6000, 22'd3,  1'b0, 1'b0},   // R2 ule gt
        '{1'b1, 2'd3, 4'b1111, 32'h0,        3'd1, 32'h0000_7000, 22'd4,  1'b1, 1'b1},   // R3 zero
        '{1'b1, 2'd0, 4'b0000, 32'hFFFF_FFFB, 3'd2, 32'h0000_7000, 22'd4, 1'b0, 1'b1},   // R3 le
        '{1'b1, 2'd0, 4'b0000, 32'h0000_0005, 3'd2, 32'h0000_7000, 22'd4, 1'b0, 1'b0},   // R3 le pos
        '{1'b1, 2'd0, 4'b0000, 32'h8000_0000, 3'd3, 32'h0000_7000, 22'd4, 1'b0, 1'b1},   // R3 neg
        '{1'b1, 2'd0, 4'b0000, 32'h0,        3'd5, 32'h0000_7000, 22'd4,  1'b1, 1'b0},   // R3 nz
        '{1'b1, 2'd0, 4'b0000, 32'h7FFF_FFFF, 3'd6, 32'h0000_8000, 22'd9, 1'b0, 1'b1},   // R3 gt
        '{1'b1, 2'd0, 4'b0000, 32'h0,        3'd6, 32'h0000_8000, 22'd9,  1'b0, 1'b0},   // R3 gt zero
        '{1'b1, 2'd0, 4'b0000, 32'h0,        3'd7, 32'h0000_8000, 22'd9,  1'b0, 1'b1},   // R3 ge
        '{1'b1, 2'd0, 4'b0000, 32'hFFFF_FFFF, 3'd7, 32'h0000_8000, 22'd9, 1'b1, 1'b0},   // R3 ge neg
        '{1'b1, 2'd3, 4'b1111, 32'h0,        3'd0, 32'h0000_9000, 22'd6,  1'b1, 1'b0},   // R4 code 0
        '{1'b1, 2'd3, 4'b1111, 32'hFFFF_FFFF, 3'd4, 32'h0000_9000, 22'd6, 1'b0, 1'b0}    // R4 code 4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_mode = 1'b0;
    logic [1:0]  in_fcc = '0;
    logic [3:0]  in_fcond = '0;
    logic [31:0] in_rval = '0;
    logic [2:0]  in_rcond = '0;
    logic [31:0] in_pc = '0;
    logic [21:0] in_disp = '0;
    logic        in_pred_taken = 1'b0;
    logic        res_valid, res_taken, res_mispredict, res_bp_update;
    logic [31:0] res_next_pc;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_resolver i_branch_resolver (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_fcc(in_fcc), .in_fcond(in_fcond), .in_rval(in_rval), .in_rcond(in_rcond),
        .in_pc(in_pc), .in_disp(in_disp), .in_pred_taken(in_pred_taken),
        .res_valid(res_valid), .res_taken(res_taken), .res_next_pc(res_next_pc),
        .res_mispredict(res_mispredict), .res_bp_update(res_bp_update)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic drive(input vec_t v);
        in_valid = 1'b1; in_mode = v.mode; in_fcc = v.fcc; in_fcond = v.fcond;
        in_rval = v.rval; in_rcond = v.rcond; in_pc = v.pc; in_disp = v.disp;
        in_pred_taken = v.pred;
    endtask

    task automatic expect_result(input vec_t v, input string tag);
        logic [31:0] npc;
        npc = v.exp_taken ? v.pc + ({{10{v.disp[21]}}, v.disp} << 2) : v.pc + 32'd8;
        check({tag, " R9 valid"}, 32'(res_valid), 32'd1);
        check({tag, " R1-R4 taken"}, 32'(res_taken), 32'(v.exp_taken));
        check(v.exp_taken ? {tag, " R5 target"} : {tag, " R6 fallthrough"}, res_next_pc, npc);
        check({tag, " R8 mispredict"}, 32'(res_mispredict), 32'(v.exp_taken != v.pred));
        check({tag, " R7 strobe"}, 32'(res_bp_update), 32'(v.mode || v.fcond != 4'b0000));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        vec_t w;
        repeat (3) @(negedge clk);
        check("R10 valid in reset", 32'(res_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 valid after reset", 32'(res_valid), 32'd0);
        check("R9 quiet strobe", 32'(res_bp_update), 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(negedge clk);
            in_valid = 1'b0;
            expect_result(VECS[i], $sformatf("vec%0d", i));
        end

        // R9: idle cycle drops valid and gated outputs
        @(negedge clk);
        check("R9 idle valid", 32'(res_valid), 32'd0);
        check("R9 idle taken", 32'(res_taken), 32'd0);

        // R9: back-to-back branches, one result per cycle
        @(negedge clk);
        drive(VECS[4]);
        @(negedge clk);
        expect_result(VECS[4], "b2b0");
        drive(VECS[15]);
        @(negedge clk);
        expect_result(VECS[15], "b2b1");
        drive(VECS[7]);
        @(negedge clk);
        in_valid = 1'b0;
        expect_result(VECS[7], "b2b2");

        // R6: fallthrough wraps past zero
        w = '{1'b1, 2'd0, 4'b0000, 32'h1, 3'd1, 32'hFFFF_FFFC, 22'd3, 1'b0, 1'b0};
        @(negedge clk);
        drive(w);
        @(negedge clk);
        in_valid = 1'b0;
        expect_result(w, "wrap");
        check("R6 wrap value", res_next_pc, 32'h0000_0004);

        // R5: large negative displacement
        w = '{1'b0, 2'd3, 4'b1000, 32'h0, 3'd0, 32'h0000_0100, 22'h200000, 1'b1, 1'b1};
        @(negedge clk);
        drive(w);
        @(negedge clk);
        in_valid = 1'b0;
        expect_result(w, "negdisp");

        // R10: reset discards a pending result
        @(negedge clk);
        drive(VECS[0]);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset discards", 32'(res_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 stays idle", 32'(res_valid), 32'd0);

        finish_run();
    end
endmodule